// File: doc/BRIEF.md
# Phase-Adjustable Carrier Clock Divider

This block runs on a carrier clock and turns it into a slower square-like waveform whose frequency is the carrier divided by a programmable integer N. A free-running up-counter walks through the values 0 to N-1. Two compare points inside that range decide where the output rises and where it falls. Because the two points always move by the same amount, modulo N, a controller can slide the output edges earlier or later by whole carrier cycles while the frequency and the high time stay the same.

Control is plain and strobe based. One strobe loads a new divisor, which also restores the default compare points: rise at count 0 and fall at count N/2. A second strobe adds a signed step to both compare points. An enable level freezes or runs the divider, and a start strobe restarts the count from a known point. Commands first update a pending copy of the settings. The running copy takes them over only when the counter wraps or when a start strobe arrives, so a change never produces a shortened pulse. The block has no streaming data path, so none of its pins carry a valid/ready handshake.

Top module: `cdiv_top`

## Requirements
- R1: After reset, count_o is 0, wave_o is 0, and the active divisor is 128 with the rise point at 0 and the fall point at 64.
- R2: While en_i is high and start_i is low, count_o advances by one on each clock from 0 to N-1 and then returns to 0, so one output period is N clocks.
- R3: wave_o goes high on the clock after count_o equals the rise point and goes low on the clock after count_o equals the fall point. The high time is therefore (fall - rise) mod N clocks, and the first sample with wave_o high shows count_o = (rise + 1) mod N.
- R4: A pulse on set_div_i with value D makes N = D, puts the rise point at 0 and the fall point at floor(N/2). Any D below 2 is treated as 2.
- R5: A pulse on step_i adds the signed two's-complement value step_val_i to both compare points and reduces each result into the range 0 to N-1. Stepping -1 from 0 gives N-1, and steps larger in magnitude than N wrap correctly.
- R6: When set_div_i and step_i are high in the same cycle, the divisor load takes effect and the phase step is discarded.
- R7: Commands change only the pending settings, and successive steps accumulate there. The running settings take the pending ones only at the clock where count_o wraps from N-1 to 0, or on a start strobe. A command registered on the wrap clock itself takes effect one period later.
- R8: Both running compare points always lie below the running divisor.
- R9: A pulse on start_i forces count_o to 0 and wave_o low on the next clock, and loads the pending settings at once, whatever the level of en_i.
- R10: While en_i is low and start_i is low, count_o and wave_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Carrier clock; every register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run level; low freezes counter and output |
| start_i | input | 1 | Restart strobe: clears the count and loads pending settings |
| set_div_i | input | 1 | Divisor load strobe |
| div_val_i | input | 16 | Divisor value taken with set_div_i |
| step_i | input | 1 | Phase step strobe |
| step_val_i | input | 16 | Signed phase step taken with step_i |
| wave_o | output | 1 | Divided output waveform |
| count_o | output | 16 | Current counter value |

## Verification
The hardest case to reach from the ports is a phase step whose strobe lands exactly on the clock where the counter wraps. At that clock the running copy loads the old pending value while the pending copy takes the new step. To reach it, the stimulus watches count_o until it reads N-1 and drives the step strobe in that same cycle. It then checks that in the next period the output still rises at the old position, and that it rises one cycle later only in the period after that. Negative wrap-around and steps larger than the period are covered by stepping below zero and by stepping with N+3 at every divide ratio.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int unsigned CDIV_W   = 16;
  localparam int unsigned CDIV_DEF = 128;
  localparam int unsigned CDIV_MIN = 2;

  typedef logic [CDIV_W-1:0] cdiv_val_t;

  typedef struct packed {
    cdiv_val_t per;
    cdiv_val_t cmp_a;
    cdiv_val_t cmp_b;
  } cdiv_cfg_t;

  // Settings for a freshly loaded divisor: rise at 0, fall at half period.
  function automatic cdiv_cfg_t cdiv_for_ratio(cdiv_val_t d);
    cdiv_cfg_t c;
    c.per   = (d < CDIV_W'(CDIV_MIN)) ? CDIV_W'(CDIV_MIN) : d;
    c.cmp_a = '0;
    c.cmp_b = c.per >> 1;
    return c;
  endfunction

  // Move x by r (already below per) forward or backward, modulo per.
  function automatic cdiv_val_t cdiv_shift(cdiv_val_t x, cdiv_val_t r,
                                           logic back, cdiv_val_t per);
    logic [CDIV_W:0] s;
    if (back) begin
      if (x >= r) s = {1'b0, x} - {1'b0, r};
      else        s = {1'b0, x} + {1'b0, per} - {1'b0, r};
    end else begin
      s = {1'b0, x} + {1'b0, r};
      if (s >= {1'b0, per}) s = s - {1'b0, per};
    end
    return CDIV_W'(s);
  endfunction

  localparam cdiv_cfg_t CDIV_RST_CFG = cdiv_for_ratio(CDIV_W'(CDIV_DEF));

endpackage

// File: rtl/cdiv_shadow.sv
module cdiv_shadow
  import cdiv_pkg::*;
#(
  parameter int unsigned STEP_W = CDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_div_i,
  input  cdiv_val_t         div_val_i,
  input  logic              step_i,
  input  logic [STEP_W-1:0] step_val_i,
  output cdiv_cfg_t         pend_o
);

  localparam int unsigned MAG_W = STEP_W + 1;
  localparam int unsigned RED_W = (MAG_W > CDIV_W) ? MAG_W : CDIV_W;

  cdiv_cfg_t         pend_q;
  logic              back;
  logic [MAG_W-1:0]  sx;
  logic [MAG_W-1:0]  mag;
  logic [RED_W-1:0]  mag_w;
  logic [RED_W-1:0]  per_w;
  logic [RED_W-1:0]  red;
  cdiv_val_t         red_n;

  // Magnitude of the signed step, then one remainder by the pending period.
  always_comb begin
    back  = step_val_i[STEP_W-1];
    sx    = {step_val_i[STEP_W-1], step_val_i};
    mag   = back ? (~sx + 1'b1) : sx;
    mag_w = RED_W'(mag);
    per_w = RED_W'(pend_q.per);
    red   = mag_w % per_w;
    red_n = CDIV_W'(red);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CDIV_RST_CFG;
    end else if (set_div_i) begin
      pend_q <= cdiv_for_ratio(div_val_i);
    end else if (step_i) begin
      pend_q.cmp_a <= cdiv_shift(pend_q.cmp_a, red_n, back, pend_q.per);
      pend_q.cmp_b <= cdiv_shift(pend_q.cmp_b, red_n, back, pend_q.per);
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/cdiv_count.sv
module cdiv_count
  import cdiv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      start_i,
  input  cdiv_cfg_t pend_i,
  output cdiv_val_t cnt_o,
  output cdiv_cfg_t live_o
);

  cdiv_val_t cnt_q;
  cdiv_cfg_t live_q;
  logic      last;

  assign last = (cnt_q == live_q.per - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      live_q <= CDIV_RST_CFG;
    end else if (start_i) begin
      cnt_q  <= '0;
      live_q <= pend_i;
    end else if (en_i) begin
      if (last) begin
        cnt_q  <= '0;
        live_q <= pend_i;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign live_o = live_q;

endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave
  import cdiv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      start_i,
  input  cdiv_val_t cnt_i,
  input  cdiv_cfg_t live_i,
  output logic      wave_o
);

  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (start_i) begin
      wave_q <= 1'b0;
    end else if (en_i) begin
      if (cnt_i == live_i.cmp_a)      wave_q <= 1'b1;
      else if (cnt_i == live_i.cmp_b) wave_q <= 1'b0;
    end
  end

  assign wave_o = wave_q;

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
  import cdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              set_div_i,
  input  logic [CDIV_W-1:0] div_val_i,
  input  logic              step_i,
  input  logic [CDIV_W-1:0] step_val_i,
  output logic              wave_o,
  output logic [CDIV_W-1:0] count_o
);

  cdiv_cfg_t pend_cfg;
  cdiv_cfg_t live_cfg;
  cdiv_val_t cnt;

  cdiv_shadow #(.STEP_W(CDIV_W)) shadow_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_div_i  (set_div_i),
    .div_val_i  (div_val_i),
    .step_i     (step_i),
    .step_val_i (step_val_i),
    .pend_o     (pend_cfg)
  );

  cdiv_count count_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_i),
    .pend_i  (pend_cfg),
    .cnt_o   (cnt),
    .live_o  (live_cfg)
  );

  cdiv_wave wave_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_i),
    .cnt_i   (cnt),
    .live_i  (live_cfg),
    .wave_o  (wave_o)
  );

  assign count_o = cnt;

endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk
  import cdiv_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      en,
  input logic      start,
  input cdiv_val_t count,
  input logic      wave,
  input cdiv_cfg_t live
);

  // R2: counter steps by one below the wrap value
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && count != live.per - 1'b1) |=> count == $past(count) + 1'b1);

  // R2: counter returns to zero after the last value
  a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && count == live.per - 1'b1) |=> count == '0);

  // R3: rise point drives the output high
  a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && count == live.cmp_a) |=> wave);

  // R3: fall point drives the output low
  a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && count == live.cmp_b && count != live.cmp_a) |=> !wave);

  // R8: compare points and count stay inside the period
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (live.cmp_a < live.per) && (live.cmp_b < live.per) && (count < live.per));

  // R7: running settings change only at a wrap or a start
  a_r7_apply_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(en && count == live.per - 1'b1)) |=> $stable(live));

  // R9: start clears count and output
  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0) && !wave);

  // R10: disabled divider holds
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> $stable(count) && $stable(wave));

endmodule

bind cdiv_top cdiv_chk chk_i (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .en    (en_i),
  .start (start_i),
  .count (count_o),
  .wave  (wave_o),
  .live  (live_cfg)
);

// File: tb/cdiv_top_tb_top.sv
module cdiv_top_tb_top;
  import cdiv_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              en;
  logic              start;
  logic              set_div;
  logic [CDIV_W-1:0] div_val;
  logic              step;
  logic [CDIV_W-1:0] step_val;
  logic              wave;
  logic [CDIV_W-1:0] count;

  cdiv_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .start_i    (start),
    .set_div_i  (set_div),
    .div_val_i  (div_val),
    .step_i     (step),
    .step_val_i (step_val),
    .wave_o     (wave),
    .count_o    (count)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int m_n    = 128;
  int m_a    = 0;
  int m_b    = 64;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tk;
    @(negedge clk);
  endtask

  task automatic drive_set(input int v);
    set_div = 1'b1;
    div_val = CDIV_W'(v);
    tk();
    set_div = 1'b0;
    m_n = (v < 2) ? 2 : v;
    m_a = 0;
    m_b = m_n / 2;
  endtask

  task automatic drive_step(input int d);
    step     = 1'b1;
    step_val = CDIV_W'(d);
    tk();
    step = 1'b0;
    m_a = ((m_a + d) % m_n + m_n) % m_n;
    m_b = ((m_b + d) % m_n + m_n) % m_n;
  endtask

  task automatic wait_count(input int v, input string req);
    int g;
    for (g = 0; g < 1000; g++) begin
      if (int'(count) == v) break;
      tk();
    end
    if (g == 1000) check(1'b0, req, "timeout waiting for count", int'(count), v);
  endtask

  // Checks rise position, high time and period against the model.
  task automatic measure(input string req);
    int seen = 0;
    int t1, tf, t2, c1;
    bit prev;
    int g;
    for (g = 0; g < 1000 && seen < 2; g++) begin
      tk();
      if (count == '0) seen++;
    end
    prev = wave;
    for (g = 0; g < 1000; g++) begin
      tk();
      if (!prev && wave) break;
      prev = wave;
    end
    t1 = cyc;
    c1 = int'(count);
    for (g = 0; g < 1000; g++) begin
      tk();
      if (!wave) break;
    end
    tf = cyc;
    for (g = 0; g < 1000; g++) begin
      tk();
      if (wave) break;
    end
    t2 = cyc;
    check(c1 == (m_a + 1) % m_n, req, "count at rise", c1, (m_a + 1) % m_n);
    check(tf - t1 == (m_b - m_a + m_n) % m_n, req, "high time", tf - t1,
          (m_b - m_a + m_n) % m_n);
    check(t2 - t1 == m_n, req, "period", t2 - t1, m_n);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; start = 1'b0; set_div = 1'b0; step = 1'b0;
    div_val = '0; step_val = '0;
    repeat (3) tk();
    rst_n = 1'b1;
    tk();
    check(count == '0, "R1", "count after reset", int'(count), 0);
    check(wave == 1'b0, "R1", "wave after reset", int'(wave), 0);
    en = 1'b1;
    measure("R1");
  endtask

  task automatic t_ratio(input int n);
    drive_set(n);
    measure("R4");
    drive_step(1);
    measure("R5");
    drive_step(-1);
    drive_step(-1);
    measure("R5");
    drive_step(m_n + 3);
    measure("R5");
    drive_step(-(m_n + 1));
    measure("R2");
  endtask

  task automatic t_clamp;
    drive_set(1);
    measure("R4");
    drive_set(0);
    measure("R4");
  endtask

  task automatic t_collide;
    drive_set(16);
    set_div  = 1'b1;
    div_val  = CDIV_W'(32);
    step     = 1'b1;
    step_val = CDIV_W'(5);
    tk();
    set_div = 1'b0;
    step    = 1'b0;
    m_n = 32; m_a = 0; m_b = 16;
    measure("R6");
  endtask

  task automatic t_accum;
    drive_set(32);
    drive_step(1);
    drive_step(1);
    measure("R7");
  endtask

  task automatic t_wrap_edge;
    drive_set(16);
    measure("R7");
    wait_count(15, "R7");
    drive_step(1);
    check(count == '0, "R7", "count after wrap", int'(count), 0);
    tk();
    check(wave == 1'b1, "R7", "old phase kept for one period", int'(wave), 1);
    wait_count(0, "R7");
    tk();
    check(wave == 1'b0, "R7", "new phase: still low at count 1", int'(wave), 0);
    tk();
    check(wave == 1'b1, "R7", "new phase: high at count 2", int'(wave), 1);
  endtask

  task automatic t_start;
    drive_set(128);
    measure("R9");
    repeat (7) tk();
    drive_set(16);
    start = 1'b1;
    tk();
    start = 1'b0;
    check(count == '0, "R9", "count after start", int'(count), 0);
    check(wave == 1'b0, "R9", "wave after start", int'(wave), 0);
    tk();
    check(wave == 1'b1, "R9", "rise after start", int'(wave), 1);
    repeat (15) tk();
    check(count == '0, "R9", "new period used at once", int'(count), 0);
    repeat (5) tk();
    en    = 1'b0;
    start = 1'b1;
    tk();
    start = 1'b0;
    check(count == '0, "R9", "start while disabled", int'(count), 0);
    repeat (3) tk();
    check(count == '0, "R10", "disabled after start holds", int'(count), 0);
    en = 1'b1;
  endtask

  task automatic t_enable;
    int c;
    bit w;
    drive_set(32);
    measure("R10");
    repeat (5) tk();
    c  = int'(count);
    w  = wave;
    en = 1'b0;
    repeat (5) tk();
    check(int'(count) == c, "R10", "count frozen", int'(count), c);
    check(wave == w, "R10", "wave frozen", int'(wave), int'(w));
    en = 1'b1;
    tk();
    check(int'(count) == (c + 1) % m_n, "R10", "count resumes", int'(count),
          (c + 1) % m_n);
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    foreach (m_list[i]) t_ratio(m_list[i]);
    t_clamp();
    t_collide();
    t_accum();
    t_wrap_edge();
    t_start();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  int m_list [5] = '{128, 64, 32, 16, 5};

endmodule